// File: doc/BRIEF.md
# Register-Stack Frame Spill Controller

This block reshapes the current stack frame of a processor whose local registers are a 64-entry circular window over a stack that lives in memory. On a start request it moves the frame pointer down by a parameter count and records a new frame length code. It then checks whether the resized frame, plus a fixed reserve of ten registers, still fits in the part of the window that lies between the frame pointer and the stack pointer.

When the frame does not fit, the block copies the oldest window entries out to memory, one word at a time, over a valid/ready write port. The stack pointer advances by four on every accepted write. Before the first write, the block compares the old stack pointer against an upper stack bound. If the bound was reached, it raises a frame-error trap request together with its completion pulse, once the last write has been accepted.

The stack pointer, frame pointer and bound are preset through a load port. The window mode flag is cleared on every run.

Top module: `frame_spill_ctrl`

## Requirements
- R1: When start is accepted while idle, fp becomes fp minus 4 times src_cnt, fl takes the value of dst_len, and m_flag becomes 0 from the next cycle on.
- R2: A dst_len code of 0 counts as 16 registers in the fit calculation, while fl still reads 0.
- R3: The available count is (sp[7:2] minus new fp[7:2]) modulo 64. It is 64 instead when that result is 0 and sp differs from the new fp.
- R4: The shortfall is the available count minus (frame length plus 10), taken as a 7-bit signed value. When it is zero or positive, done pulses in the cycle after start, and no write is issued and no trap is raised.
- R5: When the shortfall is negative, exactly its magnitude of writes are issued. Each write has mem_addr equal to sp and mem_wdata equal to the window entry indexed by sp[7:2], which is read through rf_addr.
- R6: sp increases by 4 only on a cycle where mem_valid and mem_ready are both high. mem_valid and mem_addr hold steady while mem_ready is low.
- R7: trap_req is raised only when a spill was needed and the old sp was greater than or equal to ub (unsigned). It is high only in the cycle of the done pulse, after the last write.
- R8: busy is high from the cycle after start is accepted through the done cycle. done is a single-cycle pulse. A start while busy is ignored.
- R9: The window index sp[7:2] wraps from 63 to 0 when sp crosses a 256-byte boundary during a spill, while the address keeps counting up.
- R10: A load pulse while idle writes sp, fp, ub and m_flag from the load inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load pointers and flag |
| ld_sp | input | 32 | Stack pointer load value |
| ld_fp | input | 32 | Frame pointer load value |
| ld_ub | input | 32 | Upper stack bound load value |
| ld_m | input | 1 | Mode flag load value |
| start | input | 1 | Begin frame restructure |
| src_cnt | input | 4 | Count of passed parameters |
| dst_len | input | 4 | New frame length code (0 means 16) |
| sp | output | 32 | Stack pointer |
| fp | output | 32 | Frame pointer |
| fl | output | 4 | Frame length code |
| m_flag | output | 1 | Window mode flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| trap_req | output | 1 | Frame-error trap request |
| rf_addr | output | 6 | Window read index |
| rf_data | input | 32 | Window read data |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Write request accepted |
| mem_addr | output | 32 | Write byte address |
| mem_wdata | output | 32 | Write data |

## Verification
The hardest case to reach is a completely full window, where sp and the new fp have the same window index. The count is then 0 when the two pointers are equal and 64 when they differ by a multiple of 256 bytes. Both cases are reached by loading the pointers directly through the load port and choosing src_cnt so that the moved frame pointer lands on sp or 256 bytes away from it. A spill that starts at index 62 covers the wrap of the index. The memory side stalls on a repeating pattern, so every spill also runs through held requests.

// File: rtl/frame_spill_ctrl.sv
module frame_spill_ctrl #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int RESERVE = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_sp,
  input  logic [AW-1:0] ld_fp,
  input  logic [AW-1:0] ld_ub,
  input  logic          ld_m,
  input  logic          start,
  input  logic [3:0]    src_cnt,
  input  logic [3:0]    dst_len,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] fp,
  output logic [3:0]    fl,
  output logic          m_flag,
  output logic          busy,
  output logic          done,
  output logic          trap_req,
  output logic [5:0]    rf_addr,
  input  logic [DW-1:0] rf_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);

  typedef enum logic [1:0] {IDLE, SPILL, FIN} state_t;
  state_t state;

  logic [AW-1:0] ub;
  logic          err;
  logic [6:0]    left;

  logic [AW-1:0] new_fp;
  logic [5:0]    idx_diff;
  logic [6:0]    avail, need, slack;
  logic          go;

  assign go       = start && (state == IDLE);
  assign new_fp   = fp - {{(AW-6){1'b0}}, src_cnt, 2'b00};
  assign idx_diff = sp[7:2] - new_fp[7:2];
  assign avail    = (idx_diff == 6'd0 && sp != new_fp) ? 7'd64 : {1'b0, idx_diff};
  assign need     = ((dst_len == 4'd0) ? 7'd16 : {3'b000, dst_len}) + 7'(RESERVE);
  assign slack    = avail - need;

  assign busy      = (state != IDLE);
  assign done      = (state == FIN);
  assign trap_req  = (state == FIN) && err;
  assign mem_valid = (state == SPILL);
  assign mem_addr  = sp;
  assign rf_addr   = sp[7:2];
  assign mem_wdata = rf_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= IDLE;
      sp     <= '0;
      fp     <= '0;
      ub     <= '0;
      fl     <= '0;
      m_flag <= 1'b0;
      err    <= 1'b0;
      left   <= '0;
    end else begin
      case (state)
        IDLE: begin
          if (go) begin
            fp     <= new_fp;
            fl     <= dst_len;
            m_flag <= 1'b0;
            left   <= -slack;
            err    <= slack[6] && (sp >= ub);
            state  <= slack[6] ? SPILL : FIN;
          end else if (ld_en) begin
            sp     <= ld_sp;
            fp     <= ld_fp;
            ub     <= ld_ub;
            m_flag <= ld_m;
          end
        end
        SPILL: begin
          if (mem_ready) begin
            sp   <= sp + AW'(4);
            left <= left - 7'd1;
            if (left == 7'd1) state <= FIN;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R6
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (sp == $past(sp) + AW'(4)));

  // R6
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  // R1
  m_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (!m_flag && fl == $past(dst_len)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R7
  trap_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ($past(mem_valid && mem_ready) || !$past(busy)));

endmodule

// File: tb/test_frame_spill_ctrl.sv
`timescale 1ns/1ps
module test_frame_spill_ctrl;
  logic clk = 0, rst_n = 0;
  logic ld_en = 0, ld_m = 0, start = 0;
  logic [31:0] ld_sp = 0, ld_fp = 0, ld_ub = 0;
  logic [3:0] src_cnt = 0, dst_len = 0;
  logic [31:0] sp, fp, mem_addr, mem_wdata, rf_data;
  logic [3:0] fl;
  logic m_flag, busy, done, trap_req, mem_valid, mem_ready = 0;
  logic [5:0] rf_addr;

  always #2 clk = ~clk;

  frame_spill_ctrl i_frame_spill_ctrl (.*);

  // window entry value: 0xC0DE0000 plus index
  assign rf_data = {16'hC0DE, 10'd0, rf_addr};

  int checks = 0, fails = 0, cyc = 0;
  logic [1:0] rc = 0;
  always @(negedge clk) begin rc <= rc + 2'd1; mem_ready <= (rc != 2'd1); end

  logic clr_log = 0;
  int nw = 0;
  logic [31:0] wa [0:63];
  logic [31:0] wd [0:63];
  always @(posedge clk) begin
    if (clr_log) nw <= 0;
    else if (mem_valid && mem_ready) begin
      wa[nw[5:0]] <= mem_addr; wd[nw[5:0]] <= mem_wdata; nw <= nw + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: actual %0d cycles, expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  localparam int NV = 8;
  localparam logic [31:0] V_SP [0:NV-1] = '{32'h100, 32'h1B0, 32'h200, 32'h300, 32'h3F8, 32'h100, 32'h500, 32'h3F8};
  localparam logic [31:0] V_FP [0:NV-1] = '{32'h080, 32'h080, 32'h20C, 32'h300, 32'h3F0, 32'h080, 32'h400, 32'h3F0};
  localparam logic [31:0] V_UB [0:NV-1] = '{32'h1000, 32'h10000, 32'h10000, 32'h300, 32'h10000, 32'h0, 32'h10000, 32'h10};
  localparam logic [3:0]  V_LS [0:NV-1] = '{4'd0, 4'd2, 4'd3, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0};
  localparam logic [3:0]  V_LD [0:NV-1] = '{4'd4, 4'd5, 4'd0, 4'd1, 4'd2, 4'd4, 4'd0, 4'd2};
  localparam logic [31:0] V_EFP[0:NV-1] = '{32'h080, 32'h078, 32'h200, 32'h300, 32'h3F0, 32'h080, 32'h400, 32'h3F0};
  localparam int          V_NS [0:NV-1] = '{0, 1, 26, 11, 10, 0, 0, 10};
  localparam logic        V_TR [0:NV-1] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};

  task automatic load(input logic [31:0] s, input logic [31:0] f, input logic [31:0] u);
    @(negedge clk); ld_en = 1; ld_sp = s; ld_fp = f; ld_ub = u; ld_m = 1;
    @(negedge clk); ld_en = 0;
  endtask

  int wait_n;
  logic early_trap, seen_trap;
  task automatic run(input logic [3:0] ls, input logic [3:0] ld, input int mid_start);
    clr_log = 1; @(negedge clk); clr_log = 0;
    start = 1; src_cnt = ls; dst_len = ld;
    @(negedge clk); start = 0;
    wait_n = 0; early_trap = 0; seen_trap = 0;
    while (!done && wait_n < 500) begin
      if (trap_req) early_trap = 1;
      if (wait_n == 3 && mid_start != 0) begin start = 1; dst_len = 4'd7; src_cnt = 4'd5; end
      else start = 0;
      @(negedge clk); wait_n++;
    end
    start = 0;
    seen_trap = trap_req;
    if (wait_n >= 500) begin fails++; $display("FAIL R8: done never seen, actual timeout expected done"); end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset busy", {31'd0, busy}, 0);
    chk("R8 reset done", {31'd0, done}, 0);
    chk("R5 reset mem_valid", {31'd0, mem_valid}, 0);
    chk("R6 reset sp", sp, 0);
    rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      load(V_SP[v], V_FP[v], V_UB[v]);
      chk("R10 load sp", sp, V_SP[v]);
      chk("R10 load m", {31'd0, m_flag}, 1);
      run(V_LS[v], V_LD[v], 0);
      chk("R7 trap at done", {31'd0, seen_trap}, {31'd0, V_TR[v]});
      chk("R7 no early trap", {31'd0, early_trap}, 0);
      chk("R4 R5 write count", nw, V_NS[v]);
      chk("R1 fp", fp, V_EFP[v]);
      chk("R1 R2 fl", {28'd0, fl}, {28'd0, V_LD[v]});
      chk("R1 m cleared", {31'd0, m_flag}, 0);
      for (int k = 0; k < V_NS[v] && k < 64; k++) begin
        chk("R5 R9 write addr", wa[k], V_SP[v] + 32'(4 * k));
        chk("R5 R9 write data", wd[k], {16'hC0DE, 10'd0, 6'((V_SP[v] >> 2) + 32'(k))});
      end
      chk("R6 final sp", sp, V_SP[v] + 32'(4 * V_NS[v]));
      @(negedge clk);
      chk("R8 idle after done", {31'd0, busy}, 0);
    end

    // R3: same index, pointers 256 bytes apart -> 64 available; need 15 -> no spill
    load(32'h900, 32'h800, 32'h0);
    run(4'd0, 4'd5, 0);
    chk("R3 full-window count 64", nw, 0);
    chk("R3 no trap", {31'd0, seen_trap}, 0);

    // R8: start during a spill ignored; R2: code 0 spills 26 from an empty window
    load(32'h600, 32'h600, 32'h10000);
    run(4'd0, 4'd0, 1);
    chk("R8 start while busy ignored fl", {28'd0, fl}, 0);
    chk("R8 start while busy ignored fp", fp, 32'h600);
    chk("R2 code 0 spill count", nw, 26);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule